// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block sequences an analog-to-digital converter through a scan of enabled channels each time a selected trigger fires. It talks to the converter through a plain handshake. It drives a channel select and a one-cycle start pulse, then waits for a done pulse that carries the result. Every finished conversion leaves the block as a one-cycle result strobe. The strobe carries the channel number, a flag that marks a touch-panel measurement, and the result value.

In touch-panel mode, a run of four consecutive channels begins at a programmable offset. These four channels are enabled whether or not their mask bits are set. When the scan reaches the first of them, a touch sub-sequence takes over. For each of the four channels it drives a distinct 2-bit panel drive code, and holds that code for a programmable settle time before it starts the conversion. The ordinary scan then continues above the group.

The block also powers the converter down when software asks for sleep while the block is idle. After that power-down, the next sequence waits a programmable startup time before its first conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, ready is 1, adc_pwr is 1, and adc_start, res_valid, touch_busy and overrun are 0.
- R2: A sequence starts only from a trigger pulse that the trigger-mode field selects. Mode 1 selects sw_trig and mode 7 selects evt_trig. Mode 0 and every other value start nothing, and a pulse on the input that is not selected starts nothing.
- R3: Enabled channels are converted one at a time in ascending order, one result each. Every result strobe reports the channel that was selected at its start and the adc_data present with its adc_done. For an ordinary channel, res_touch is 0.
- R4: A trigger with no channel enabled issues no start and produces no result. Ready returns to 1 within two cycles.
- R5: With cfg_touch_en set, channels cfg_touch_ofs to cfg_touch_ofs+3 are converted even when their bits in cfg_chan_en are clear. They are converted in ascending order with res_touch 1, and each produces one result. The offset must not exceed NUM_CH-4.
- R6: During a touch conversion, touch_busy is 1 and touch_pat carries the code of the step: 0, 1, 2 and 3 for group channels +0 to +3. The code and touch_busy are held unchanged for exactly cfg_settle+1 cycles before adc_start rises. Outside the group, touch_pat is 0.
- R7: In touch mode, enabled channels below the group are converted before it and those above it after it. All of them are converted as ordinary channels.
- R8: A selected trigger that arrives while a sequence runs does not start another sequence. It sets overrun, which stays 1 until reset.
- R9: cfg_sleep clears adc_pwr one cycle after the block is idle with the request present. While a sequence runs, adc_pwr stays 1.
- R10: If adc_pwr is 0 when a sequence is accepted, the first start is delayed by cfg_startup cycles. If cfg_startup is 0, there is no delay. adc_pwr becomes 1 when the sequence is accepted.
- R11: adc_start is a single-cycle pulse, and it is never 1 while ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chan_en | input | NUM_CH | Channel enable mask |
| cfg_trig_mode | input | 3 | Trigger source: 0 off, 1 software, 7 event |
| cfg_touch_en | input | 1 | Touch-panel mode enable |
| cfg_touch_ofs | input | CH_W | First channel of the touch group |
| cfg_settle | input | SETTLE_W | Touch drive settle cycles |
| cfg_sleep | input | 1 | Converter power-down request |
| cfg_startup | input | START_W | Wake delay in clock cycles |
| sw_trig | input | 1 | Software trigger pulse |
| evt_trig | input | 1 | Peripheral event trigger pulse |
| adc_sel | output | CH_W | Converter channel select |
| adc_start | output | 1 | Converter start pulse |
| adc_done | input | 1 | Converter done pulse |
| adc_data | input | RES_W | Converter result |
| adc_pwr | output | 1 | Converter active |
| touch_pat | output | 2 | Panel drive code |
| touch_busy | output | 1 | Touch sub-sequence driving the panel |
| res_valid | output | 1 | Result strobe |
| res_chan | output | CH_W | Result channel |
| res_touch | output | 1 | Result belongs to the touch group |
| res_data | output | RES_W | Result value |
| ready | output | 1 | Block idle |
| overrun | output | 1 | Sticky trigger-while-busy flag |

## Verification
The hardest situation to reach from the ports is the hand-over between the ordinary scan and the touch group. This is the case where the group sits in the middle of the mask, ordinary channels lie on both sides of it, and none of its own mask bits are set. The bench reaches it with a mask that touches only channels 0 and 7 and an offset of 2. It reaches the other boundary with an offset at the top of the range, where group channels are also set in the mask. A bench-side converter model answers every start. A monitor records the drive code and how long it has been stable at each start. This shows that the settle hold is exact and the order is correct at both edges of the group.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_SCAN,
      ST_TSET,
      ST_CONV
   } seq_state_e;

   localparam logic [2:0] TRIG_SOFT  = 3'd1;
   localparam logic [2:0] TRIG_EVENT = 3'd7;

endpackage

// File: rtl/adcseq_pick.sv
// Lowest enabled channel at or above a start index.
module adcseq_pick #(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 4
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [IDX_W-1:0]  from,
   output logic              found,
   output logic [IDX_W-1:0]  ch
);

   always_comb begin
      found = 1'b0;
      ch    = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mask[i] && (IDX_W'(i) >= from)) begin
            found = 1'b1;
            ch    = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/adcseq_touch.sv
// Step index and settle counter of the touch sub-sequence.
module adcseq_touch #(
   parameter int SETTLE_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enter,
   input  logic                next,
   input  logic                launch,
   input  logic [SETTLE_W-1:0] settle_len,
   output logic [1:0]          step,
   output logic                settle_done
);

   logic [SETTLE_W-1:0] cnt;
   logic                armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step  <= 2'd0;
         cnt   <= '0;
         armed <= 1'b0;
      end else if (enter) begin
         step  <= 2'd0;
         cnt   <= settle_len;
         armed <= 1'b1;
      end else if (next) begin
         step  <= step + 2'd1;
         cnt   <= settle_len;
         armed <= 1'b1;
      end else if (launch) begin
         armed <= 1'b0;
      end else if (armed && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign settle_done = armed && (cnt == '0);

   // R6
   launch_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> settle_done);

endmodule

// File: rtl/adcseq_wake.sv
// Startup delay counter used after the converter was powered down.
module adcseq_wake #(
   parameter int START_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [START_W-1:0] val,
   output logic               expire
);

   logic [START_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expire = (cnt == START_W'(1));

   // R10
   wake_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (val != '0));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adcseq_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int RES_W    = 12,
   parameter int SETTLE_W = 4,
   parameter int START_W  = 8,
   parameter int CH_W     = $clog2(NUM_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   cfg_chan_en,
   input  logic [2:0]          cfg_trig_mode,
   input  logic                cfg_touch_en,
   input  logic [CH_W-1:0]     cfg_touch_ofs,
   input  logic [SETTLE_W-1:0] cfg_settle,
   input  logic                cfg_sleep,
   input  logic [START_W-1:0]  cfg_startup,
   input  logic                sw_trig,
   input  logic                evt_trig,
   output logic [CH_W-1:0]     adc_sel,
   output logic                adc_start,
   input  logic                adc_done,
   input  logic [RES_W-1:0]    adc_data,
   output logic                adc_pwr,
   output logic [1:0]          touch_pat,
   output logic                touch_busy,
   output logic                res_valid,
   output logic [CH_W-1:0]     res_chan,
   output logic                res_touch,
   output logic [RES_W-1:0]    res_data,
   output logic                ready,
   output logic                overrun
);

   localparam int IDX_W = CH_W + 1;

   if (NUM_CH < 4) begin : g_bad_ch
      $error("adc_seq_ctrl: NUM_CH must be at least 4");
   end
   if (CH_W < 2) begin : g_bad_chw
      $error("adc_seq_ctrl: CH_W too small");
   end
   if (RES_W < 1 || SETTLE_W < 1 || START_W < 1) begin : g_bad_w
      $error("adc_seq_ctrl: widths must be positive");
   end

   seq_state_e          state;
   logic [IDX_W-1:0]    idx, sel_q, t_ofs_x, grp_ch, pk_ch;
   logic [NUM_CH-1:0]   grp_mask, seq_mask;
   logic [CH_W-1:0]     t_ofs;
   logic                t_en, in_grp, start_q, pwr_q, ovr_q;
   logic                rv_q, rt_q;
   logic [CH_W-1:0]     rch_q;
   logic [RES_W-1:0]    rd_q;
   logic                trig_hit, pk_found;
   logic                wk_load, wk_expire;
   logic                ts_enter, ts_next, ts_launch, ts_done;
   logic [1:0]          ts_step;

   assign trig_hit = ((cfg_trig_mode == TRIG_SOFT)  && sw_trig) ||
                     ((cfg_trig_mode == TRIG_EVENT) && evt_trig);

   // Force-enable mask of the touch group
   for (genvar g = 0; g < NUM_CH; g++) begin : g_grp
      assign grp_mask[g] = cfg_touch_en &&
                           (IDX_W'(g) >= {1'b0, cfg_touch_ofs}) &&
                           (IDX_W'(g) <  ({1'b0, cfg_touch_ofs} + IDX_W'(4)));
   end

   assign t_ofs_x = {1'b0, t_ofs};
   assign grp_ch  = t_ofs_x + IDX_W'(ts_step);

   adcseq_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
      .mask  (seq_mask),
      .from  (idx),
      .found (pk_found),
      .ch    (pk_ch)
   );

   assign wk_load = (state == ST_IDLE) && trig_hit && !pwr_q && (cfg_startup != '0);

   adcseq_wake #(.START_W(START_W)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (wk_load),
      .val    (cfg_startup),
      .expire (wk_expire)
   );

   assign ts_enter  = (state == ST_SCAN) && pk_found && t_en && (pk_ch == t_ofs_x);
   assign ts_next   = (state == ST_CONV) && adc_done && in_grp && (ts_step != 2'd3);
   assign ts_launch = (state == ST_TSET) && ts_done;

   adcseq_touch #(.SETTLE_W(SETTLE_W)) u_touch (
      .clk         (clk),
      .rst_n       (rst_n),
      .enter       (ts_enter),
      .next        (ts_next),
      .launch      (ts_launch),
      .settle_len  (cfg_settle),
      .step        (ts_step),
      .settle_done (ts_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         sel_q    <= '0;
         start_q  <= 1'b0;
         in_grp   <= 1'b0;
         seq_mask <= '0;
         t_en     <= 1'b0;
         t_ofs    <= '0;
         pwr_q    <= 1'b1;
         ovr_q    <= 1'b0;
         rv_q     <= 1'b0;
         rch_q    <= '0;
         rt_q     <= 1'b0;
         rd_q     <= '0;
      end else begin
         start_q <= 1'b0;
         rv_q    <= 1'b0;
         if (trig_hit && (state != ST_IDLE))
            ovr_q <= 1'b1;
         if ((state == ST_IDLE) && trig_hit)
            pwr_q <= 1'b1;
         else if ((state == ST_IDLE) && cfg_sleep)
            pwr_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (trig_hit) begin
                  seq_mask <= cfg_chan_en | grp_mask;
                  t_en     <= cfg_touch_en;
                  t_ofs    <= cfg_touch_ofs;
                  idx      <= '0;
                  in_grp   <= 1'b0;
                  state    <= wk_load ? ST_WAKE : ST_SCAN;
               end
            end
            ST_WAKE: begin
               if (wk_expire)
                  state <= ST_SCAN;
            end
            ST_SCAN: begin
               if (!pk_found) begin
                  state <= ST_IDLE;
               end else if (ts_enter) begin
                  state <= ST_TSET;
               end else begin
                  sel_q   <= pk_ch;
                  start_q <= 1'b1;
                  state   <= ST_CONV;
               end
            end
            ST_TSET: begin
               sel_q <= grp_ch;
               if (ts_done) begin
                  start_q <= 1'b1;
                  in_grp  <= 1'b1;
                  state   <= ST_CONV;
               end
            end
            ST_CONV: begin
               if (adc_done) begin
                  rv_q  <= 1'b1;
                  rch_q <= sel_q[CH_W-1:0];
                  rt_q  <= in_grp;
                  rd_q  <= adc_data;
                  if (in_grp) begin
                     if (ts_step == 2'd3) begin
                        in_grp <= 1'b0;
                        idx    <= t_ofs_x + IDX_W'(4);
                        state  <= ST_SCAN;
                     end else begin
                        state <= ST_TSET;
                     end
                  end else begin
                     idx   <= sel_q + IDX_W'(1);
                     state <= ST_SCAN;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign adc_sel    = sel_q[CH_W-1:0];
   assign adc_start  = start_q;
   assign adc_pwr    = pwr_q;
   assign ready      = (state == ST_IDLE);
   assign overrun    = ovr_q;
   assign touch_busy = (state == ST_TSET) || ((state == ST_CONV) && in_grp);
   assign touch_pat  = touch_busy ? ts_step : 2'b00;
   assign res_valid  = rv_q;
   assign res_chan   = rch_q;
   assign res_touch  = rt_q;
   assign res_data   = rd_q;

   // R11
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);
   // R11
   ready_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !adc_start);
   // R3
   result_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(adc_done));
   // R9
   sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_pwr |-> ready);
   // R8
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   // R10
   wake_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE) |-> !adc_start);
   // R6
   pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_busy && $past(touch_busy) && !$past(adc_done)) |-> $stable(touch_pat));

endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;

   localparam int NUM_CH = 8;
   localparam int CH_W   = 3;
   localparam int LAT    = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] cfg_chan_en = '0;
   logic [2:0]        cfg_trig_mode = 3'd0;
   logic              cfg_touch_en = 1'b0;
   logic [CH_W-1:0]   cfg_touch_ofs = '0;
   logic [3:0]        cfg_settle = '0;
   logic              cfg_sleep = 1'b0;
   logic [7:0]        cfg_startup = '0;
   logic              sw_trig = 1'b0, evt_trig = 1'b0;
   logic [CH_W-1:0]   adc_sel;
   logic              adc_start;
   logic              adc_done = 1'b0;
   logic [11:0]       adc_data = '0;
   logic              adc_pwr;
   logic [1:0]        touch_pat;
   logic              touch_busy;
   logic              res_valid;
   logic [CH_W-1:0]   res_chan;
   logic              res_touch;
   logic [11:0]       res_data;
   logic              ready;
   logic              overrun;

   always #2 clk = ~clk;

   adc_seq_ctrl #(.NUM_CH(NUM_CH), .RES_W(12), .SETTLE_W(4), .START_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_chan_en(cfg_chan_en), .cfg_trig_mode(cfg_trig_mode),
      .cfg_touch_en(cfg_touch_en), .cfg_touch_ofs(cfg_touch_ofs), .cfg_settle(cfg_settle),
      .cfg_sleep(cfg_sleep), .cfg_startup(cfg_startup), .sw_trig(sw_trig), .evt_trig(evt_trig),
      .adc_sel(adc_sel), .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
      .adc_pwr(adc_pwr), .touch_pat(touch_pat), .touch_busy(touch_busy),
      .res_valid(res_valid), .res_chan(res_chan), .res_touch(res_touch), .res_data(res_data),
      .ready(ready), .overrun(overrun));

   int total = 0, bad = 0;
   int n = 0, m = 0, nstart = 0, pend = 0, pend_sel = 0, stab = 0;
   int got_ch[32], got_t[32], got_d[32], st_pat[32], st_cnt[32];
   int exp_ch[32], exp_t[32], exp_n = 0;
   logic [2:0] prev_pt = '0;

   function automatic logic [11:0] mdl(int c);
      return 12'(12'h300 + c * 41);
   endfunction

   // converter model
   always @(negedge clk) begin
      adc_done <= 1'b0;
      if (pend > 0) begin
         if (pend == 1) begin
            adc_done <= 1'b1;
            adc_data <= mdl(pend_sel);
         end
         pend <= pend - 1;
      end else if (adc_start) begin
         pend     <= LAT;
         pend_sel <= int'(adc_sel);
      end
   end

   // result and drive-code monitor
   always @(negedge clk) begin
      if ({touch_busy, touch_pat} == prev_pt) stab = stab + 1;
      else stab = 0;
      prev_pt = {touch_busy, touch_pat};
      if (adc_start) begin
         nstart = nstart + 1;
         if (touch_busy && m < 32) begin
            st_pat[m] = int'(touch_pat);
            st_cnt[m] = stab;
            m = m + 1;
         end
      end
      if (res_valid && n < 32) begin
         got_ch[n] = int'(res_chan);
         got_t[n]  = int'(res_touch);
         got_d[n]  = int'(res_data);
         n = n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_log();
      n = 0; m = 0; nstart = 0; exp_n = 0;
   endtask

   task automatic push_exp(input int c, input int t);
      exp_ch[exp_n] = c; exp_t[exp_n] = t; exp_n++;
   endtask

   task automatic pulse(input bit ev);
      @(negedge clk);
      if (ev) evt_trig = 1'b1; else sw_trig = 1'b1;
      @(negedge clk);
      evt_trig = 1'b0; sw_trig = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (ready && pend == 0 && !adc_done) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic compare_seq(input string req);
      chk(n == exp_n, {req, " result count"}, n, exp_n);
      for (int i = 0; i < exp_n && i < n; i++) begin
         chk(got_ch[i] == exp_ch[i] && got_t[i] == exp_t[i], {req, " chan*10+touch"},
             got_ch[i] * 10 + got_t[i], exp_ch[i] * 10 + exp_t[i]);
         chk(got_d[i] == int'(mdl(exp_ch[i])), {req, " data"}, got_d[i], int'(mdl(exp_ch[i])));
      end
   endtask

   task automatic measure(output int d);
      @(negedge clk);
      sw_trig = 1'b1;
      d = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         sw_trig = 1'b0;
         d++;
         if (adc_start) break;
      end
   endtask

   task automatic t_reset();
      chk(ready == 1'b1, "R1 ready", int'(ready), 1);
      chk(adc_pwr == 1'b1, "R1 adc_pwr", int'(adc_pwr), 1);
      chk(!adc_start && !res_valid && !touch_busy, "R1 strobes", int'(adc_start), 0);
      chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
   endtask

   task automatic t_ordinary();
      clear_log();
      cfg_trig_mode = 3'd1; cfg_chan_en = 8'b1010_0101;
      pulse(1'b0);
      wait_idle();
      push_exp(0, 0); push_exp(2, 0); push_exp(5, 0); push_exp(7, 0);
      compare_seq("R3 ascending scan");
   endtask

   task automatic t_trig_modes();
      clear_log();
      cfg_chan_en = 8'b0000_0010;
      cfg_trig_mode = 3'd0; pulse(1'b0); pulse(1'b1);
      repeat (10) @(negedge clk);
      chk(nstart == 0, "R2 mode 0 ignores triggers", nstart, 0);
      cfg_trig_mode = 3'd3; pulse(1'b0); pulse(1'b1);
      repeat (10) @(negedge clk);
      chk(nstart == 0, "R2 mode 3 ignores triggers", nstart, 0);
      cfg_trig_mode = 3'd7; pulse(1'b0);
      repeat (10) @(negedge clk);
      chk(nstart == 0, "R2 mode 7 ignores sw_trig", nstart, 0);
      pulse(1'b1);
      wait_idle();
      push_exp(1, 0);
      compare_seq("R2 event trigger");
      clear_log();
      cfg_trig_mode = 3'd1; pulse(1'b1);
      repeat (10) @(negedge clk);
      chk(nstart == 0, "R2 mode 1 ignores evt_trig", nstart, 0);
   endtask

   task automatic t_empty();
      clear_log();
      cfg_trig_mode = 3'd1; cfg_chan_en = '0;
      pulse(1'b0);
      @(negedge clk);
      chk(ready == 1'b1, "R4 ready back", int'(ready), 1);
      repeat (8) @(negedge clk);
      chk(nstart == 0 && n == 0, "R4 no start or result", nstart + n, 0);
   endtask

   task automatic t_touch_mid();
      clear_log();
      cfg_touch_en = 1'b1; cfg_touch_ofs = 3'd2; cfg_settle = 4'd3;
      cfg_chan_en = 8'b1000_0001;
      pulse(1'b0);
      wait_idle();
      push_exp(0, 0); push_exp(2, 1); push_exp(3, 1); push_exp(4, 1); push_exp(5, 1); push_exp(7, 0);
      compare_seq("R5 R7 touch group mid-scan");
      chk(m == 4, "R6 touch start count", m, 4);
      for (int i = 0; i < 4 && i < m; i++) begin
         chk(st_pat[i] == i, "R6 drive code", st_pat[i], i);
         chk(st_cnt[i] == 4, "R6 settle hold", st_cnt[i], 4);
      end
   endtask

   task automatic t_touch_top();
      clear_log();
      cfg_touch_en = 1'b1; cfg_touch_ofs = 3'd4; cfg_settle = 4'd0;
      cfg_chan_en = 8'b0011_1111;
      pulse(1'b0);
      wait_idle();
      for (int i = 0; i < 4; i++) push_exp(i, 0);
      for (int i = 4; i < 8; i++) push_exp(i, 1);
      compare_seq("R5 R7 touch group at top");
      for (int i = 0; i < 4 && i < m; i++) begin
         chk(st_pat[i] == i && st_cnt[i] == 1, "R6 zero settle", st_pat[i] * 10 + st_cnt[i], i * 10 + 1);
      end
      chk(touch_pat == 2'b00 && !touch_busy, "R6 idle pattern", int'(touch_pat), 0);
      cfg_touch_en = 1'b0;
   endtask

   task automatic t_overrun();
      clear_log();
      cfg_trig_mode = 3'd1; cfg_chan_en = 8'hFF;
      chk(overrun == 1'b0, "R8 overrun clear before", int'(overrun), 0);
      pulse(1'b0);
      repeat (5) @(negedge clk);
      pulse(1'b0);
      wait_idle();
      for (int i = 0; i < 8; i++) push_exp(i, 0);
      compare_seq("R8 busy trigger ignored");
      chk(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
      repeat (5) @(negedge clk);
      chk(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);
   endtask

   task automatic t_sleep();
      int d;
      int lost;
      clear_log();
      cfg_trig_mode = 3'd1; cfg_chan_en = 8'b0000_0001; cfg_startup = 8'd0;
      measure(d);
      chk(d == 2, "R10 baseline start delay", d, 2);
      wait_idle();
      @(negedge clk); cfg_sleep = 1'b1;
      @(negedge clk);
      chk(adc_pwr == 1'b0, "R9 idle sleep", int'(adc_pwr), 0);
      cfg_sleep = 1'b0;
      measure(d);
      chk(d == 2, "R10 zero startup", d, 2);
      chk(adc_pwr == 1'b1, "R10 power restored", int'(adc_pwr), 1);
      wait_idle();
      cfg_chan_en = 8'hFF;
      pulse(1'b0);
      @(negedge clk); cfg_sleep = 1'b1;
      lost = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (ready) break;
         if (!adc_pwr) lost++;
      end
      chk(lost == 0, "R9 power held while busy", lost, 0);
      @(negedge clk);
      chk(adc_pwr == 1'b0, "R9 sleep once idle", int'(adc_pwr), 0);
      wait_idle();
      cfg_sleep = 1'b0; cfg_startup = 8'd5; cfg_chan_en = 8'b0000_0001;
      measure(d);
      chk(d == 7, "R10 startup delay", d, 7);
      wait_idle();
      measure(d);
      chk(d == 2, "R10 no delay while active", d, 2);
      wait_idle();
      chk(nstart == n, "R11 one result per start", n, nstart);
   endtask

   bit fin = 1'b0;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ordinary();
      t_trig_modes();
      t_empty();
      t_touch_mid();
      t_touch_top();
      t_overrun();
      t_sleep();
      fin = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule